// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block watches that software keeps running. A prescaled counter runs freely while the watchdog is enabled. When the counter reaches the timeout period picked by a two-bit rate code, the block sends out a one-cycle reset request and starts counting again from zero. Software holds the request off by writing a two-byte key to the service register over a plain write bus. The first byte is 55h and the second is AAh. Any other value cancels a half-entered key.

The rate code sits in a second register on the same bus. A write to that register takes effect only during a short window that opens at reset. After the window closes, the code is frozen until the next reset. A static enable input switches the whole watchdog off, and while it is off the counter is held at zero.

Top module: `cop_watchdog`

## Requirements
- R1: During reset and after it is released, `cop_rst_req` is low, the rate code is 00 and the count is zero. Counting starts at the first clock edge after release.
- R2: Rate code r gives a timeout of 2^(PRE_W+STAGE_LOG2+2r) clocks. With the defaults, codes 00, 01, 10 and 11 give 2^15, 2^17, 2^19 and 2^21 clocks. When counting starts at edge 0, the first request is sampled at edge period-1.
- R3: `cop_rst_req` is high for exactly one cycle per timeout. The count then restarts from zero, so requests repeat once every period.
- R4: A write of 55h to SVC_ADDR followed by a write of AAh to SVC_ADDR restarts the count from zero. If the AAh write is sampled at edge k, the next request falls at edge k+period.
- R5: Writes to any address other than SVC_ADDR, placed between the 55h and the AAh, neither break the key nor restart the count.
- R6: A write to SVC_ADDR of any value other than 55h or AAh cancels an armed key. A write of AAh that does not follow 55h is ignored. A new 55h re-arms the key.
- R7: A write to RATE_ADDR loads bits [1:0] of the data as the rate code, but only in the first LOCK_CYCLES clock edges after reset (edges 0 to LOCK_CYCLES-1). Later writes to RATE_ADDR are ignored.
- R8: While `cop_en` is low, the count is held at zero and no request is raised. After `cop_en` rises, counting starts from zero.
- R9: If the AAh write lands on the same edge as the terminal count, the service wins. No request is raised and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register write address |
| bus_wdata | input | 8 | Register write data |
| cop_en | input | 1 | Watchdog enable (1 = running) |
| cop_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Two events can fall on the same edge: the completion of the service key and the terminal count of the timer. The bench sets this up by placing the AAh write on the exact edge where the shortest period runs out. The test passes only if no request appears on that edge and the next request comes one full period later.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam int         NUM_RATES  = 4;

  typedef logic [1:0] rate_t;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_e;
endpackage

// File: rtl/wd_key_seq.sv
module wd_key_seq
  import wd_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              kick
);
  key_st_e st_q, st_d;
  logic    hit_svc;

  assign hit_svc = bus_we && (bus_addr == SVC_ADDR);
  assign kick    = hit_svc && (st_q == KEY_ARMED) && (bus_wdata == KEY_SECOND);

  always_comb begin
    st_d = st_q;
    if (hit_svc) begin
      if (bus_wdata == KEY_FIRST) st_d = KEY_ARMED;
      else                        st_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else if (hit_svc) st_q <= st_d;
  end

  // R6
  key_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_svc && bus_wdata != KEY_FIRST) |=> (st_q == KEY_IDLE));
  // R5
  key_other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != SVC_ADDR) |=> $stable(st_q));
  // R4
  key_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_svc && bus_wdata == KEY_FIRST) |=> (st_q == KEY_ARMED));
endmodule

// File: rtl/wd_rate_lock.sv
module wd_rate_lock
  import wd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 8'h11,
  parameter int          LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output rate_t             rate
);
  localparam int WW = $clog2(LOCK_CYCLES + 1);
  localparam logic [WW-1:0] WIN_END = WW'(LOCK_CYCLES);

  logic [WW-1:0] win_q, win_d;
  rate_t         rate_q, rate_d;
  logic          open_w, rate_ce;

  assign open_w  = (win_q < WIN_END);
  assign rate_ce = open_w && bus_we && (bus_addr == RATE_ADDR);
  assign rate    = rate_q;

  always_comb begin
    win_d  = win_q + 1'b1;
    rate_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      rate_q <= '0;
    end else begin
      if (open_w)  win_q  <= win_d;
      if (rate_ce) rate_q <= rate_d;
    end
  end

  // R7
  rate_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_END) |=> $stable(rate_q));
  // R7
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_END) |=> (win_q == WIN_END));
endmodule

// File: rtl/wd_timer.sv
module wd_timer
  import wd_pkg::*;
#(
  parameter int PRE_W      = 13,
  parameter int STAGE_LOG2 = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  kick,
  input  rate_t rate,
  output logic  req
);
  localparam int SW = STAGE_LOG2 + 2 * (NUM_RATES - 1);

  logic [PRE_W-1:0]     pre_q, pre_d;
  logic [SW-1:0]        stage_q, stage_d;
  logic [NUM_RATES-1:0] term_vec;
  logic                 pre_wrap, fire, req_q;

  genvar r;
  generate
    for (r = 0; r < NUM_RATES; r++) begin : g_term
      localparam logic [SW-1:0] LIM = {SW{1'b1}} >> (2 * (NUM_RATES - 1 - r));
      assign term_vec[r] = (stage_q == LIM);
    end
  endgenerate

  assign pre_wrap = &pre_q;
  assign fire     = en && !kick && pre_wrap && term_vec[rate];
  assign req      = req_q;

  always_comb begin
    pre_d   = pre_q + 1'b1;
    stage_d = pre_wrap ? stage_q + 1'b1 : stage_q;
    if (!en || kick || fire) begin
      pre_d   = '0;
      stage_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      stage_q <= '0;
      req_q   <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      stage_q <= stage_d;
      req_q   <= fire;
    end
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R9
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!req_q && pre_q == '0 && stage_q == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!req_q && pre_q == '0 && stage_q == '0));
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import wd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 8'h11,
  parameter int          LOCK_CYCLES = 64,
  parameter int          PRE_W       = 13,
  parameter int          STAGE_LOG2  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              cop_en,
  output logic              cop_rst_req
);
  logic  kick;
  rate_t rate;

  wd_key_seq #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .kick(kick));

  wd_rate_lock #(.ADDR_W(ADDR_W), .RATE_ADDR(RATE_ADDR),
                 .LOCK_CYCLES(LOCK_CYCLES)) u_rate (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rate(rate));

  wd_timer #(.PRE_W(PRE_W), .STAGE_LOG2(STAGE_LOG2)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(cop_en), .kick(kick), .rate(rate),
    .req(cop_rst_req));

  // R4
  svc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !cop_rst_req);
endmodule

// File: tb/cop_watchdog_bench.sv
module cop_watchdog_bench;
  localparam logic [7:0] SVC   = 8'h10;
  localparam logic [7:0] RATEA = 8'h11;
  localparam logic [7:0] OTHER = 8'h20;
  localparam int PRE_W = 2;
  localparam int SLOG  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic cop_en = 1'b1;
  logic cop_rst_req;

  int checks = 0, errors = 0;
  int edge_n;
  int first_req, last_req, req_cnt, pulse_err;
  logic prev_req;
  bit done = 0;

  always #10 clk = ~clk;

  cop_watchdog #(.SVC_ADDR(SVC), .RATE_ADDR(RATEA), .LOCK_CYCLES(64),
                 .PRE_W(PRE_W), .STAGE_LOG2(SLOG)) u_cop_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cop_en(cop_en), .cop_rst_req(cop_rst_req));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_n <= -1;
    else        edge_n <= edge_n + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cop_rst_req) begin
        req_cnt++;
        last_req = edge_n;
        if (first_req < 0) first_req = edge_n;
        if (prev_req) pulse_err++;
      end
      prev_req = cop_rst_req;
    end
  end

  function automatic int period(input int r);
    return 1 << (PRE_W + SLOG + 2 * r);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; cop_en = en;
    repeat (3) @(negedge clk);
    chk(cop_rst_req == 1'b0, "R1 req low in reset", cop_rst_req, 0);
    first_req = -1; last_req = -1; req_cnt = 0; pulse_err = 0; prev_req = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_until(input int e);
    while (edge_n < e) @(negedge clk);
  endtask

  task automatic write_at(input int e, input logic [7:0] a, input logic [7:0] d);
    run_until(e - 1);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // {rate, first key byte, second key byte, edge of first byte}
  localparam logic [33:0] VEC [9] = '{
    {2'd0, 8'h55, 8'hAA, 16'd5},
    {2'd1, 8'h55, 8'hAA, 16'd20},
    {2'd2, 8'h55, 8'hAA, 16'd100},
    {2'd3, 8'h55, 8'hAA, 16'd500},
    {2'd0, 8'h55, 8'h55, 16'd3},
    {2'd1, 8'hAA, 8'hAA, 16'd10},
    {2'd1, 8'h55, 8'h54, 16'd10},
    {2'd2, 8'h54, 8'hAA, 16'd40},
    {2'd3, 8'h00, 8'h00, 16'd40}
  };

  initial begin
    #(20ns * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Vector table: R2 period per rate, R4 key restart, R5 foreign write between, R6 bad keys
    for (int v = 0; v < 9; v++) begin
      int r, k, p, ex;
      logic [7:0] d1, d2;
      r  = int'(VEC[v][33:32]);
      d1 = VEC[v][31:24];
      d2 = VEC[v][23:16];
      k  = int'(VEC[v][15:0]);
      p  = period(r);
      ex = (d1 == 8'h55 && d2 == 8'hAA) ? (k + 2 + p) : (p - 1);
      do_reset(1'b1);
      write_at(0, RATEA, {6'd0, r[1:0]});
      write_at(k, SVC, d1);
      write_at(k + 1, OTHER, 8'hAA);
      write_at(k + 2, SVC, d2);
      run_until(ex + 1);
      chk(first_req == ex, $sformatf("R2/R4/R5/R6 vec%0d first request edge", v), first_req, ex);
      chk(req_cnt == 1, $sformatf("R3 vec%0d single pulse", v), req_cnt, 1);
    end

    // R6 cancel then AA ignored; R1 default rate 00
    do_reset(1'b1);
    write_at(2, SVC, 8'h55);
    write_at(3, SVC, 8'h12);
    write_at(4, SVC, 8'hAA);
    run_until(16);
    chk(first_req == 15, "R6 cancelled key", first_req, 15);

    // R6 re-arm after cancel, R4 restart
    do_reset(1'b1);
    write_at(2, SVC, 8'h55);
    write_at(3, SVC, 8'h12);
    write_at(4, SVC, 8'h55);
    write_at(5, SVC, 8'hAA);
    run_until(22);
    chk(first_req == 21, "R6 re-armed key", first_req, 21);

    // R7 write after window ignored; R3 periodic pulses
    do_reset(1'b1);
    write_at(64, RATEA, 8'h01);
    run_until(80);
    chk(last_req == 79, "R7 late rate write ignored", last_req, 79);
    chk(req_cnt == 5, "R3 periodic requests", req_cnt, 5);

    // R7 write on last open edge accepted
    do_reset(1'b1);
    write_at(63, RATEA, 8'h01);
    run_until(128);
    chk(last_req == 127, "R7 last window edge accepted", last_req, 127);
    chk(req_cnt == 5, "R7 request count", req_cnt, 5);

    // R9 service on terminal edge
    do_reset(1'b1);
    write_at(13, SVC, 8'h55);
    write_at(15, SVC, 8'hAA);
    run_until(32);
    chk(first_req == 31, "R9 service beats timeout", first_req, 31);

    // R8 disabled, then enabled
    do_reset(1'b0);
    run_until(100);
    chk(req_cnt == 0, "R8 no request while disabled", req_cnt, 0);
    cop_en = 1'b1;
    run_until(117);
    chk(first_req == 116, "R8 count from zero on enable", first_req, 116);
    chk(pulse_err == 0, "R3 no stretched pulse", pulse_err, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule